// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block is the central transmit state machine of an IEEE 802.3 MAC on a byte-wide datapath. It pulls payload bytes from a show-ahead transmit FIFO. Its inputs from the FIFO are the occupancy, the head byte, an end-of-frame flag and a parity-error flag. It drives a byte stream with a valid strobe, one byte per clock. Each frame gets a seven-byte preamble and a start delimiter in front. Short payloads are padded with zeros, and a CRC-32 frame check sequence is added at the end.

The sequencer sits between an inter-frame gap timer and a collision backoff unit. A frame can start only in idle, and only when all of these hold: the transmit enable is on, both halt controls are off, the gap timer reports that the line is free, and the FIFO holds enough bytes to cover the preamble time.

When a frame ends, the block reports it to the gap timer. A collision hands control to the backoff unit. The FIFO is then rewound so that the same frame is sent again. A parity error or a FIFO underrun stops the frame and flushes the FIFO. Sticky status bits record completion, parity error and underrun. A completion interrupt is raised when it is enabled.

Top module: `eth_tx_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, tx_valid, fifo_pop, fifo_flush, fifo_rewind, bo_start, gap_restart, st_done, st_perr, st_urun and irq are all 0.
- R2: A frame leaves idle only in a cycle where ctl_tx_enable=1, ctl_tx_halt=0, ctl_mac_halt=0 and gap_open=1. If any of these is not met, no byte is sent, however much data is queued.
- R3: A frame leaves idle only when fifo_level is at least 8. With fewer bytes queued, nothing is sent.
- R4: Every frame begins with seven bytes of 0x55 and then one byte of 0xD5. From the first preamble byte to the last check byte, tx_valid stays high on consecutive cycles.
- R5: After the delimiter, the payload bytes follow in FIFO order. Each is popped once. If the payload (up to and including the byte with fifo_eof=1) is shorter than 60 bytes, zero bytes are added until data plus pad is 60. A payload of 60 bytes or more is not padded.
- R6: Four check bytes follow the data and pad. The CRC-32 uses polynomial 0x04C11DB7 in bit-reflected form, is seeded with all ones and covers data plus pad. The result is complemented and sent least significant byte first.
- R7: On the last check byte, st_done becomes 1 and stays 1. gap_restart pulses for one cycle. irq equals st_done AND ctl_irq_en.
- R8: In the data phase, if the head byte has fifo_perr=1, that byte is neither sent nor popped. tx_valid drops, fifo_flush and gap_restart pulse for one cycle, st_perr becomes 1, and st_done is not set.
- R9: In the data phase, if fifo_level is 0 before the end-of-frame byte, the frame stops the same way as in R8, but with st_urun set instead of st_perr.
- R10: If line_col=1 during a frame, tx_valid is 0 from the next cycle. bo_start and fifo_rewind pulse for one cycle. The block then waits for bo_done and resends the whole frame, starting from the preamble.
- R11: stat_clear=1 clears st_done, st_perr and st_urun in the next cycle, unless a new event sets a bit in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tx_enable | input | 1 | Transmit enable control |
| ctl_tx_halt | input | 1 | Transmit halt request |
| ctl_mac_halt | input | 1 | MAC-wide halt request |
| ctl_irq_en | input | 1 | Completion interrupt enable |
| stat_clear | input | 1 | Clears the sticky status bits |
| fifo_level | input | LVL_W | Bytes held in the transmit FIFO |
| fifo_byte | input | 8 | Head byte of the FIFO |
| fifo_eof | input | 1 | Head byte ends the frame |
| fifo_perr | input | 1 | Head byte failed parity |
| fifo_pop | output | 1 | Consume the head byte |
| fifo_flush | output | 1 | Empty the FIFO (abort) |
| fifo_rewind | output | 1 | Return FIFO read point to frame start |
| gap_open | input | 1 | Gap timer: inter-frame gap has elapsed |
| gap_restart | output | 1 | Tells gap timer transmission ended |
| line_col | input | 1 | Collision detected on the line |
| bo_start | output | 1 | Start the backoff wait |
| bo_done | input | 1 | Backoff wait has ended |
| tx_byte | output | 8 | Line byte |
| tx_valid | output | 1 | tx_byte is valid |
| st_done | output | 1 | Sticky: frame completed |
| st_perr | output | 1 | Sticky: parity abort |
| st_urun | output | 1 | Sticky: underrun abort |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sends frames of 8, 20, 59, 60 and 70 bytes. These lengths separate three cases: padding to exactly 60, a single pad byte, and no padding at all. Each case also gives a different CRC. Start gating is tested in two ways: by holding back each control bit in turn while a full frame waits, and by queuing only five bytes before the rest arrive. These tests separate a level check from a control check. A collision in the middle of the payload shows whether the retransmission restarts at the preamble and sends the first payload byte again. A parity flag on byte ten, and a frame that is never finished, show the point where each abort stops the stream and which status bit each one sets.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_PAD,
        S_FCS,
        S_BOFF
    } tx_state_e;

    typedef struct packed {
        logic done;
        logic perr;
        logic urun;
    } tx_events_t;

    function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    localparam logic [31:0] CRC_POLY_REFL = bit_reverse32(CRC_POLY);

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || seed) acc_q <= CRC_SEED;
        else if (upd)    acc_q <= crc_step(acc_q, din);
    end

    assign fcs = ~acc_q;

    a_r6_seed_hold: assert property (@(posedge clk) disable iff (rst)
        (!seed && !upd) |=> $stable(fcs));
endmodule

// File: rtl/eth_tx_status.sv
module eth_tx_status
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       irq_en,
    input  tx_events_t ev,
    output tx_events_t flags,
    output logic       irq
);
    tx_events_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (clr ? '0 : flags_q) | ev;
    end

    assign flags = flags_q;
    assign irq   = flags_q.done & irq_en;

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.done && !clr) |=> flags_q.done);
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && ev == '0) |=> flags_q == '0);
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int START_LVL   = 8,
    parameter int PRE_LEN     = 8,
    parameter int MIN_PAYLOAD = 60,
    parameter int FCS_LEN     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_tx_enable,
    input  logic             ctl_tx_halt,
    input  logic             ctl_mac_halt,
    input  logic             ctl_irq_en,
    input  logic             stat_clear,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [7:0]       fifo_byte,
    input  logic             fifo_eof,
    input  logic             fifo_perr,
    output logic             fifo_pop,
    output logic             fifo_flush,
    output logic             fifo_rewind,
    input  logic             gap_open,
    output logic             gap_restart,
    input  logic             line_col,
    output logic             bo_start,
    input  logic             bo_done,
    output logic [7:0]       tx_byte,
    output logic             tx_valid,
    output logic             st_done,
    output logic             st_perr,
    output logic             st_urun,
    output logic             irq
);
    localparam int IDX_N = (PRE_LEN > FCS_LEN) ? PRE_LEN : FCS_LEN;
    localparam int IDX_W = $clog2(IDX_N);
    localparam int CNT_W = $clog2(MIN_PAYLOAD + 1);

    tx_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    logic       start_ok, in_frame, col_hit, has_head;
    logic       take_data, take_pad, pay_full;
    logic       crc_seed, crc_upd;
    logic [7:0] crc_din, fcs_pick;
    logic [31:0] fcs_word, fcs_shift;
    tx_events_t ev, flags;

    assign has_head  = (fifo_level != '0);
    assign start_ok  = ctl_tx_enable && !ctl_tx_halt && !ctl_mac_halt && gap_open
                       && (fifo_level >= LVL_W'(START_LVL));
    assign in_frame  = (st_q == S_PRE) || (st_q == S_DATA) || (st_q == S_PAD) || (st_q == S_FCS);
    assign col_hit   = in_frame && line_col;
    assign take_data = (st_q == S_DATA) && !line_col && has_head && !fifo_perr;
    assign take_pad  = (st_q == S_PAD) && !line_col;
    assign pay_full  = (int'(cnt_q) + 1) >= MIN_PAYLOAD;

    assign ev.done = (st_q == S_FCS) && !line_col && (idx_q == IDX_W'(FCS_LEN - 1));
    assign ev.perr = (st_q == S_DATA) && !line_col && has_head && fifo_perr;
    assign ev.urun = (st_q == S_DATA) && !line_col && !has_head;

    assign fifo_pop  = take_data;
    assign crc_seed  = (st_q == S_IDLE) && start_ok;
    assign crc_upd   = take_data || take_pad;
    assign crc_din   = take_data ? fifo_byte : 8'h00;
    assign fcs_shift = fcs_word >> {idx_q, 3'b000};
    assign fcs_pick  = fcs_shift[7:0];

    eth_tx_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .seed (crc_seed),
        .upd  (crc_upd),
        .din  (crc_din),
        .fcs  (fcs_word)
    );

    eth_tx_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .clr    (stat_clear),
        .irq_en (ctl_irq_en),
        .ev     (ev),
        .flags  (flags),
        .irq    (irq)
    );

    assign st_done = flags.done;
    assign st_perr = flags.perr;
    assign st_urun = flags.urun;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            idx_q       <= '0;
            cnt_q       <= '0;
            tx_byte     <= '0;
            tx_valid    <= 1'b0;
            fifo_flush  <= 1'b0;
            fifo_rewind <= 1'b0;
            bo_start    <= 1'b0;
            gap_restart <= 1'b0;
        end else begin
            tx_valid    <= 1'b0;
            fifo_flush  <= 1'b0;
            fifo_rewind <= 1'b0;
            bo_start    <= 1'b0;
            gap_restart <= 1'b0;
            if (col_hit) begin
                bo_start    <= 1'b1;
                fifo_rewind <= 1'b1;
                st_q        <= S_BOFF;
            end else begin
                unique case (st_q)
                    S_IDLE: begin
                        if (start_ok) begin
                            st_q  <= S_PRE;
                            idx_q <= '0;
                        end
                    end
                    S_PRE: begin
                        tx_valid <= 1'b1;
                        if (idx_q == IDX_W'(PRE_LEN - 1)) begin
                            tx_byte <= SFD_BYTE;
                            st_q    <= S_DATA;
                            cnt_q   <= '0;
                        end else begin
                            tx_byte <= PRE_BYTE;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (ev.perr || ev.urun) begin
                            fifo_flush  <= 1'b1;
                            gap_restart <= 1'b1;
                            st_q        <= S_IDLE;
                        end else begin
                            tx_valid <= 1'b1;
                            tx_byte  <= fifo_byte;
                            if (!pay_full) cnt_q <= cnt_q + 1'b1;
                            if (fifo_eof) begin
                                st_q  <= pay_full ? S_FCS : S_PAD;
                                idx_q <= '0;
                            end
                        end
                    end
                    S_PAD: begin
                        tx_valid <= 1'b1;
                        tx_byte  <= 8'h00;
                        cnt_q    <= cnt_q + 1'b1;
                        if (pay_full) begin
                            st_q  <= S_FCS;
                            idx_q <= '0;
                        end
                    end
                    S_FCS: begin
                        tx_valid <= 1'b1;
                        tx_byte  <= fcs_pick;
                        if (ev.done) begin
                            gap_restart <= 1'b1;
                            st_q        <= S_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    S_BOFF: begin
                        if (bo_done) st_q <= S_IDLE;
                    end
                    default: st_q <= S_IDLE;
                endcase
            end
        end
    end

    a_r2_start_gated: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && (!ctl_tx_enable || ctl_tx_halt || ctl_mac_halt || !gap_open))
        |=> (st_q == S_IDLE || st_q == S_BOFF) && !tx_valid);
    a_r3_start_level: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && fifo_level < LVL_W'(START_LVL)) |=> st_q != S_PRE);
    a_r4_sfd_last: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DATA && $past(st_q) == S_PRE) |-> (tx_valid && tx_byte == SFD_BYTE));
    a_r8_no_bad_pop: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (!fifo_perr && fifo_level != '0));
    a_r8_flush_flag: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (st_perr || st_urun));
    a_r10_bo_pulse: assert property (@(posedge clk) disable iff (rst)
        bo_start |=> (!bo_start && !tx_valid));
endmodule

// File: tb/tb_eth_tx_seq.sv
module tb_eth_tx_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       ctl_tx_enable = 0, ctl_tx_halt = 0, ctl_mac_halt = 0, ctl_irq_en = 1;
    logic       stat_clear = 0, gap_open = 1, line_col = 0, bo_done = 0;
    logic [7:0] fifo_level = 0, fifo_byte = 0;
    logic       fifo_eof = 0, fifo_perr = 0;
    logic       fifo_pop, fifo_flush, fifo_rewind, gap_restart, bo_start;
    logic [7:0] tx_byte;
    logic       tx_valid, st_done, st_perr, st_urun, irq;

    eth_tx_seq dut (
        .clk(clk), .rst(rst), .ctl_tx_enable(ctl_tx_enable), .ctl_tx_halt(ctl_tx_halt),
        .ctl_mac_halt(ctl_mac_halt), .ctl_irq_en(ctl_irq_en), .stat_clear(stat_clear),
        .fifo_level(fifo_level), .fifo_byte(fifo_byte), .fifo_eof(fifo_eof),
        .fifo_perr(fifo_perr), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
        .fifo_rewind(fifo_rewind), .gap_open(gap_open), .gap_restart(gap_restart),
        .line_col(line_col), .bo_start(bo_start), .bo_done(bo_done), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .st_done(st_done), .st_perr(st_perr), .st_urun(st_urun), .irq(irq)
    );

    int total = 0, bad = 0;
    bit [7:0] mem[$];
    bit       mlast[$], mperr[$];
    int       rd = 0, fstart = 0;
    bit [7:0] expq[$], frame_exp[$];
    int       seen = 0, gaps = 0, bos = 0, flushes = 0, bo_cnt = 0;
    bit       pend_pop = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit [31:0] ref_crc(input bit [7:0] q[$]);
        bit [31:0] c = 32'hFFFF_FFFF;
        foreach (q[i]) begin
            for (int b = 0; b < 8; b++) begin
                bit fb = c[0] ^ q[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic drive_fifo();
        int lvl = mem.size() - rd;
        fifo_level = (lvl > 255) ? 8'd255 : 8'(lvl);
        if (lvl > 0) begin
            fifo_byte = mem[rd]; fifo_eof = mlast[rd]; fifo_perr = mperr[rd];
        end else begin
            fifo_byte = 0; fifo_eof = 0; fifo_perr = 0;
        end
    endtask

    task automatic tick();
        #1 pend_pop = (fifo_pop === 1'b1);
        @(negedge clk);
        if (tx_valid) begin
            seen++;
            if (expq.size() == 0) chk(0, "R5", "unexpected byte", tx_byte, -1);
            else begin
                bit [7:0] e = expq.pop_front();
                chk(tx_byte == e, "R4/R5/R6", "line byte", tx_byte, e);
            end
        end
        if (gap_restart) gaps++;
        if (pend_pop) begin
            if (mlast[rd]) fstart = rd + 1;
            rd++;
        end
        if (fifo_rewind) rd = fstart;
        if (fifo_flush) begin
            flushes++; mem.delete(); mlast.delete(); mperr.delete(); rd = 0; fstart = 0;
        end
        bo_done = 0;
        if (bo_cnt > 0) begin
            bo_cnt--;
            if (bo_cnt == 0) bo_done = 1;
        end
        if (bo_start) begin
            bos++; bo_cnt = 6; expq = frame_exp;
        end
        drive_fifo();
    endtask

    task automatic push(input int n, input int seed, input bit with_last, input int perr_at);
        for (int i = 0; i < n; i++) begin
            mem.push_back(8'((i * 37 + seed * 11 + 3) & 255));
            mlast.push_back(with_last && (i == n - 1));
            mperr.push_back(i == perr_at);
        end
        drive_fifo();
    endtask

    task automatic build_exp(input int n, input int seed, input int cut);
        bit [7:0] body[$];
        bit [31:0] f;
        frame_exp.delete();
        for (int i = 0; i < 7; i++) frame_exp.push_back(8'h55);
        frame_exp.push_back(8'hD5);
        for (int i = 0; i < n; i++) body.push_back(8'((i * 37 + seed * 11 + 3) & 255));
        if (cut >= 0) begin
            for (int i = 0; i < cut; i++) frame_exp.push_back(body[i]);
        end else begin
            while (body.size() < 60) body.push_back(8'h00);
            f = ref_crc(body);
            foreach (body[i]) frame_exp.push_back(body[i]);
            for (int i = 0; i < 4; i++) frame_exp.push_back(f[8*i +: 8]);
        end
        expq = frame_exp;
    endtask

    task automatic wait_drain(input int lim);
        int c = 0;
        while (expq.size() != 0 && c < lim) begin tick(); c++; end
        repeat (4) tick();
    endtask

    task automatic send_frame(input int n, input int seed, input string req);
        int g0 = gaps;
        stat_clear = 1; tick(); stat_clear = 0;
        seen = 0;
        build_exp(n, seed, -1);
        push(n, seed, 1, -1);
        wait_drain(400);
        chk(expq.size() == 0, req, "frame bytes left", expq.size(), 0);
        chk(seen == 8 + ((n < 60) ? 60 : n) + 4, req, "frame length", seen, 8 + ((n < 60) ? 60 : n) + 4);
        chk(st_done == 1, "R7", "done flag", st_done, 1);
        chk(gaps - g0 == 1, "R7", "gap restart pulses", gaps - g0, 1);
        chk(mem.size() - rd == 0, "R5", "fifo drained", mem.size() - rd, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk(tx_valid == 0 && fifo_pop == 0 && bo_start == 0, "R1", "outputs in reset", tx_valid, 0);
        rst = 0;
        tick();
        chk({tx_valid, fifo_flush, fifo_rewind, bo_start, gap_restart} == 0, "R1", "pulses after reset",
            {tx_valid, fifo_flush, fifo_rewind, bo_start, gap_restart}, 0);
        chk({st_done, st_perr, st_urun, irq} == 0, "R1", "status after reset", {st_done, st_perr, st_urun, irq}, 0);

        // R2: each gate held in turn with a full frame queued
        seen = 0;
        build_exp(20, 1, -1);
        push(20, 1, 1, -1);
        repeat (20) tick();
        chk(seen == 0, "R2", "bytes with enable off", seen, 0);
        ctl_tx_enable = 1; ctl_tx_halt = 1; repeat (20) tick();
        chk(seen == 0, "R2", "bytes with tx halt", seen, 0);
        ctl_tx_halt = 0; ctl_mac_halt = 1; repeat (20) tick();
        chk(seen == 0, "R2", "bytes with mac halt", seen, 0);
        ctl_mac_halt = 0; gap_open = 0; repeat (20) tick();
        chk(seen == 0, "R2", "bytes with gap closed", seen, 0);
        gap_open = 1;
        wait_drain(400);
        chk(expq.size() == 0 && seen == 72, "R2", "frame after gates open", seen, 72);
        chk(st_done == 1 && irq == 1, "R7", "irq with enable", irq, 1);

        // R3: level threshold
        stat_clear = 1; tick(); stat_clear = 0;
        chk(st_done == 0, "R11", "done cleared", st_done, 0);
        seen = 0;
        build_exp(8, 2, -1);
        push(5, 2, 0, -1);
        repeat (25) tick();
        chk(seen == 0, "R3", "bytes with five queued", seen, 0);
        for (int i = 5; i < 8; i++) begin
            mem.push_back(8'((i * 37 + 2 * 11 + 3) & 255));
            mlast.push_back(i == 7); mperr.push_back(0);
        end
        drive_fifo();
        wait_drain(400);
        chk(expq.size() == 0 && seen == 72, "R5", "short frame padded", seen, 72);

        send_frame(59, 3, "R5");
        send_frame(60, 4, "R6");
        send_frame(70, 5, "R6");

        // R7: interrupt disabled
        ctl_irq_en = 0;
        send_frame(30, 6, "R7");
        chk(irq == 0, "R7", "irq masked", irq, 0);
        ctl_irq_en = 1; tick();
        chk(irq == 1, "R7", "irq unmasked", irq, 1);

        // R10: collision in mid payload
        stat_clear = 1; tick(); stat_clear = 0;
        seen = 0; bos = 0;
        build_exp(30, 7, -1);
        push(30, 7, 1, -1);
        while (seen < 15) tick();
        line_col = 1; tick(); line_col = 0;
        chk(tx_valid == 0, "R10", "valid after collision", tx_valid, 0);
        wait_drain(400);
        chk(bos == 1, "R10", "backoff starts", bos, 1);
        chk(expq.size() == 0 && seen == 15 + 72, "R10", "retransmitted bytes", seen, 87);
        chk(st_done == 1, "R10", "done after retry", st_done, 1);

        // R8: parity abort at payload byte 10
        stat_clear = 1; tick(); stat_clear = 0;
        seen = 0; flushes = 0;
        build_exp(20, 8, 10);
        push(20, 8, 1, 10);
        wait_drain(400);
        repeat (3) tick();
        chk(seen == 18, "R8", "bytes before parity abort", seen, 18);
        chk(flushes == 1 && mem.size() == 0, "R8", "fifo flushed", flushes, 1);
        chk(st_perr == 1 && st_done == 0 && st_urun == 0, "R8", "parity status", {st_perr, st_done, st_urun}, 4);

        // R9: underrun
        stat_clear = 1; tick(); stat_clear = 0;
        chk(st_perr == 0, "R11", "perr cleared", st_perr, 0);
        seen = 0; flushes = 0;
        build_exp(12, 9, 12);
        push(12, 9, 0, -1);
        wait_drain(400);
        repeat (3) tick();
        chk(seen == 20, "R9", "bytes before underrun", seen, 20);
        chk(flushes == 1, "R9", "underrun flush", flushes, 1);
        chk(st_urun == 1 && st_done == 0 && st_perr == 0, "R9", "underrun status", {st_urun, st_done, st_perr}, 4);
        stat_clear = 1; tick(); stat_clear = 0;
        chk(st_urun == 0, "R11", "urun cleared", st_urun, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule